// File: doc/BRIEF.md
# ADC Serial Command Register Interface

This block is the digital control front end of a dual simultaneous-sampling converter. A host sends a 12-bit command word, most significant bit first, on a serial data line. A select strobe frames the word, and a serial clock that idles high paces it. Each bit is captured on a falling edge of the serial clock. The word takes effect on the rising edge of the 12th serial clock in the frame. At that point the block updates a configuration register and decodes its fields. It also emits one-cycle pulses that arm a DAC write, arm a DAC read, or reset the device.

Two mode pins complete the configuration. The automatic-channel pin replaces the serial channel field with an internal toggle. That toggle alternates between the two channel pairs after each conversion-done pulse. The single-output pin selects whether the two results leave on two serial outputs or share one. All serial inputs are assumed to be already synchronous to the system clock. The design samples them once per system clock to find edges, so the serial clock must be at most a quarter of the system clock rate.

Top module: `adc_cmd_if`

## Requirements
- R1: After a synchronous active-low reset, the configuration register is 0x000. Every decoded output is 0, the effective channel code is 00, and no pulse is active.
- R2: A frame shifts 12 bits MSB-first on serial clock falling edges while ser_sel is high. On the 12th rising edge the word's fields appear on the outputs.
- R3: A frame whose select drops before 12 falling edges leaves every output unchanged and produces no pulse. Falling edges after the 12th in a frame are ignored.
- R4: Action field word[2:0] = 001 gives exactly one one-cycle dac_wr_arm pulse. Code 011 gives exactly one one-cycle dac_rd_arm pulse. Codes other than 001, 011 and 101 give no pulse. At most one of the four pulse outputs is high in any cycle.
- R5: Action code 101 gives one dev_reset pulse and returns the whole configuration to 0x000 instead of loading the word. It also returns the automatic channel toggle to channel pair 0.
- R6: A word whose feature field word[9:8] is 10 leaves the register and the toggle unchanged. It emits no action pulse and instead gives one cmd_err pulse.
- R7: The power-down outputs follow the stored word: pd_deep is bit 7, pd_nap is bit 6, pd_autonap is bit 5 and pd_ref is bit 4. special_rd follows bit 3.
- R8: With mode_auto low, chan_code equals word[11:10]. pos_sel is 0 for code 00, 1 for code 01 and 2 for codes 10 and 11, meaning ch0+, ch1- and ch1+. neg_sel is 1 only for code 11, meaning ch1- as opposed to ch0-.
- R9: With mode_auto high, the serial channel field is ignored and chan_code is 00 or 11. The code flips on each conv_done pulse. conv_done has no effect while mode_auto is low.
- R10: dual_out is 1 when mode_single is low and 0 when it is high.
- R11: feat_code shows word[9:8]. extra_en is 1 only when that field is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, idles high |
| ser_sel | input | 1 | Frame select strobe, active high |
| ser_din | input | 1 | Serial command data |
| mode_auto | input | 1 | 1 = automatic channel alternation |
| mode_single | input | 1 | 1 = both results on one serial output |
| conv_done | input | 1 | One-cycle end-of-conversion pulse |
| chan_code | output | 2 | Effective channel-select code |
| pos_sel | output | 2 | Positive input: 0 ch0+, 1 ch1-, 2 ch1+ |
| neg_sel | output | 1 | Negative input: 0 ch0-, 1 ch1- |
| dual_out | output | 1 | 1 = both serial outputs in use |
| feat_code | output | 2 | Stored feature-enable field |
| extra_en | output | 1 | Additional features active |
| pd_deep | output | 1 | Deep power-down |
| pd_nap | output | 1 | Nap power-down |
| pd_autonap | output | 1 | Auto-nap power-down |
| pd_ref | output | 1 | Reference off |
| special_rd | output | 1 | Special read mode |
| dac_wr_arm | output | 1 | One-cycle pulse: DAC write on next access |
| dac_rd_arm | output | 1 | One-cycle pulse: DAC read on next access |
| dev_reset | output | 1 | One-cycle device reset pulse |
| cmd_err | output | 1 | One-cycle pulse: reserved feature code received |

## Verification
The bench builds the block with the default 12-bit word width. It toggles the serial clock every two system cycles, which is the fastest rate the edge detector supports. That rate brings the frame counter to its full and saturated states as well as to truncated frames. Random words exercise every action, feature and channel code together with random mode pin settings and conversion pulses. Directed frames cover the reserved feature code, the reset action taken in automatic mode, partial frames and over-long frames.

// File: rtl/adc_cmd_pkg.sv
// Package: shared types and codes for the ADC serial command interface.
// Assumes a 12-bit command word; field order is fixed by the command layout.
package adc_cmd_pkg;

    // Full command word as received, MSB first on the wire.
    typedef struct packed {
        logic [1:0] chan;
        logic [1:0] feat;
        logic       deep;
        logic       nap;
        logic       anap;
        logic       refoff;
        logic       spec;
        logic [2:0] act;
    } cmd_t;

    // Stored configuration: the word without its action field.
    typedef struct packed {
        logic [1:0] chan;
        logic [1:0] feat;
        logic       deep;
        logic       nap;
        logic       anap;
        logic       refoff;
        logic       spec;
    } conf_t;

    localparam int CMD_BITS = $bits(cmd_t);

    typedef enum logic [2:0] {
        ACT_DAC_WR = 3'b001,
        ACT_DAC_RD = 3'b011,
        ACT_RESET  = 3'b101
    } act_e;

    localparam logic [1:0] FEAT_EXTRA = 2'b01;
    localparam logic [1:0] FEAT_RSVD  = 2'b10;

endpackage

// File: rtl/adc_cmd_shift.sv
// Module: serial framer. Detects serial clock edges in the system clock
// domain, shifts bits on falling edges while selected, and raises a one-cycle
// word_vld after the rising edge that follows the last bit.
// Assumes ser_clk/ser_sel/ser_din are synchronous and ser_clk idles high.
module adc_cmd_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_sel,
    input  logic         ser_din,
    output logic         word_vld,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W + 2);
    localparam logic [CW-1:0] FULL = CW'(W);
    localparam logic [CW-1:0] DONE = CW'(W + 1);

    logic          clk_q;
    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;
    logic          fall;
    logic          rise;

    // Edge decode of the sampled serial clock.
    assign fall = clk_q & ~ser_clk;
    assign rise = ~clk_q & ser_clk;

    // Keep the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_q <= 1'b1;
        else        clk_q <= ser_clk;
    end

    // Shift bits in and count them; saturate once the word is committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (!ser_sel) begin
            cnt <= '0;
        end else if (fall && cnt < FULL) begin
            sh  <= {sh[W-2:0], ser_din};
            cnt <= cnt + 1'b1;
        end else if (rise && cnt == FULL) begin
            cnt <= DONE;
        end
    end

    // Commit strobe on the rising edge that closes a full word.
    always_ff @(posedge clk) begin
        if (!rst_n) word_vld <= 1'b0;
        else        word_vld <= ser_sel && rise && (cnt == FULL);
    end

    assign word = sh;
endmodule

// File: rtl/adc_cmd_decode.sv
// Module: command decoder. Loads the configuration register from a committed
// word, raises the action pulses and flags the reserved feature code.
// Assumes word is stable while word_vld is high.
module adc_cmd_decode
    import adc_cmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  word_vld,
    input  cmd_t  word,
    output conf_t cfg,
    output logic  wr_p,
    output logic  rd_p,
    output logic  rst_p,
    output logic  err_p,
    output logic  rst_now
);
    logic reserved;
    logic take;

    // Qualify the committed word.
    assign reserved = (word.feat == FEAT_RSVD);
    assign take     = word_vld & ~reserved;
    assign rst_now  = take && (word.act == ACT_RESET);

    // Configuration register: loaded, or cleared by the reset action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (take) begin
            if (rst_now) cfg <= '0;
            else         cfg <= '{chan: word.chan, feat: word.feat, deep: word.deep,
                                  nap: word.nap, anap: word.anap,
                                  refoff: word.refoff, spec: word.spec};
        end
    end

    // One-cycle action and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p  <= 1'b0;
            rd_p  <= 1'b0;
            rst_p <= 1'b0;
            err_p <= 1'b0;
        end else begin
            wr_p  <= take && (word.act == ACT_DAC_WR);
            rd_p  <= take && (word.act == ACT_DAC_RD);
            rst_p <= rst_now;
            err_p <= word_vld && reserved;
        end
    end
endmodule

// File: rtl/adc_cmd_chan.sv
// Module: channel control. Chooses between the stored channel field and an
// internal alternating toggle, and decodes the input pair selection.
// Assumes conv_done is a one-cycle pulse per conversion.
module adc_cmd_chan (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_mode,
    input  logic       conv_done,
    input  logic       clr,
    input  logic [1:0] man_chan,
    output logic [1:0] chan_code,
    output logic [1:0] pos_sel,
    output logic       neg_sel
);
    logic tog;

    // Alternating channel pair in automatic mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tog <= 1'b0;
        else if (clr)                   tog <= 1'b0;
        else if (auto_mode && conv_done) tog <= ~tog;
    end

    // Effective channel code.
    assign chan_code = auto_mode ? {tog, tog} : man_chan;

    // Input pair decode.
    always_comb begin
        unique case (chan_code)
            2'b00:   pos_sel = 2'd0;
            2'b01:   pos_sel = 2'd1;
            default: pos_sel = 2'd2;
        endcase
        neg_sel = (chan_code == 2'b11);
    end
endmodule

// File: rtl/adc_cmd_if.sv
// Module: top of the ADC serial command interface. Ties the framer, decoder
// and channel control together and presents decoded configuration fields.
// Assumes all inputs synchronous to clk; serial clock at most clk/4.
module adc_cmd_if
    import adc_cmd_pkg::*;
#(
    parameter int CMD_W = CMD_BITS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_clk,
    input  logic       ser_sel,
    input  logic       ser_din,
    input  logic       mode_auto,
    input  logic       mode_single,
    input  logic       conv_done,
    output logic [1:0] chan_code,
    output logic [1:0] pos_sel,
    output logic       neg_sel,
    output logic       dual_out,
    output logic [1:0] feat_code,
    output logic       extra_en,
    output logic       pd_deep,
    output logic       pd_nap,
    output logic       pd_autonap,
    output logic       pd_ref,
    output logic       special_rd,
    output logic       dac_wr_arm,
    output logic       dac_rd_arm,
    output logic       dev_reset,
    output logic       cmd_err
);
    logic             word_vld;
    logic [CMD_W-1:0] word_raw;
    conf_t            cfg;
    logic             rst_now;

    adc_cmd_shift #(.W(CMD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_sel  (ser_sel),
        .ser_din  (ser_din),
        .word_vld (word_vld),
        .word     (word_raw)
    );

    adc_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .word     (cmd_t'(word_raw)),
        .cfg      (cfg),
        .wr_p     (dac_wr_arm),
        .rd_p     (dac_rd_arm),
        .rst_p    (dev_reset),
        .err_p    (cmd_err),
        .rst_now  (rst_now)
    );

    adc_cmd_chan u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_mode (mode_auto),
        .conv_done (conv_done),
        .clr       (rst_now),
        .man_chan  (cfg.chan),
        .chan_code (chan_code),
        .pos_sel   (pos_sel),
        .neg_sel   (neg_sel)
    );

    // Decoded configuration outputs.
    assign feat_code  = cfg.feat;
    assign extra_en   = (cfg.feat == FEAT_EXTRA);
    assign pd_deep    = cfg.deep;
    assign pd_nap     = cfg.nap;
    assign pd_autonap = cfg.anap;
    assign pd_ref     = cfg.refoff;
    assign special_rd = cfg.spec;
    assign dual_out   = ~mode_single;
endmodule

// File: rtl/adc_cmd_if_chk.sv
// Module: property checker for adc_cmd_if, attached with bind below.
module adc_cmd_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_auto,
    input logic       conv_done,
    input logic [1:0] chan_code,
    input logic [1:0] feat_code,
    input logic       pd_deep,
    input logic       pd_nap,
    input logic       pd_autonap,
    input logic       pd_ref,
    input logic       special_rd,
    input logic       dac_wr_arm,
    input logic       dac_rd_arm,
    input logic       dev_reset,
    input logic       cmd_err
);
    // R4: pulses are mutually exclusive.
    p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dac_wr_arm, dac_rd_arm, dev_reset, cmd_err}));

    // R4: an arm pulse lasts one cycle.
    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_wr_arm |=> !dac_wr_arm);

    // R5: the reset action leaves a cleared configuration and channel 00.
    p_reset_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> (!pd_deep && !pd_nap && !pd_autonap && !pd_ref &&
                       !special_rd && feat_code == 2'b00 && chan_code == 2'b00));

    // R6: a rejected word leaves the configuration untouched.
    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $stable({pd_deep, pd_nap, pd_autonap, pd_ref, special_rd, feat_code}));

    // R9: automatic mode only produces the two paired codes.
    p_auto_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_auto |-> (chan_code == 2'b00 || chan_code == 2'b11));

    // R9: the automatic channel holds without a conversion or reset.
    p_auto_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_auto && $past(mode_auto) && !$past(conv_done) && !dev_reset)
        |-> $stable(chan_code));
endmodule

bind adc_cmd_if adc_cmd_if_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_auto  (mode_auto),
    .conv_done  (conv_done),
    .chan_code  (chan_code),
    .feat_code  (feat_code),
    .pd_deep    (pd_deep),
    .pd_nap     (pd_nap),
    .pd_autonap (pd_autonap),
    .pd_ref     (pd_ref),
    .special_rd (special_rd),
    .dac_wr_arm (dac_wr_arm),
    .dac_rd_arm (dac_rd_arm),
    .dev_reset  (dev_reset),
    .cmd_err    (cmd_err)
);

// File: tb/test_adc_cmd_if.sv
// Bench: directed corner frames plus seeded random frames, checked against a
// bench model of the configuration register and channel toggle.
module test_adc_cmd_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b1, ser_sel = 1'b0, ser_din = 1'b0;
    logic mode_auto = 1'b0, mode_single = 1'b0, conv_done = 1'b0;
    logic [1:0] chan_code, pos_sel, feat_code;
    logic neg_sel, dual_out, extra_en, pd_deep, pd_nap, pd_autonap, pd_ref, special_rd;
    logic dac_wr_arm, dac_rd_arm, dev_reset, cmd_err;

    int checks = 0, fails = 0;
    int n_wr = 0, n_rd = 0, n_rst = 0, n_err = 0;
    int e_wr = 0, e_rd = 0, e_rst = 0, e_err = 0;
    bit done = 1'b0;
    logic [11:0] m_cfg = 12'h000;
    logic        m_tog = 1'b0;

    always #2.5 clk = ~clk;

    adc_cmd_if i_adc_cmd_if (.*);

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (dac_wr_arm) n_wr++;
        if (dac_rd_arm) n_rd++;
        if (dev_reset)  n_rst++;
        if (cmd_err)    n_err++;
    end

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_chan();
        return mode_auto ? {m_tog, m_tog} : m_cfg[11:10];
    endfunction

    function automatic logic [1:0] exp_pos(input logic [1:0] c);
        return (c == 2'b00) ? 2'd0 : (c == 2'b01) ? 2'd1 : 2'd2;
    endfunction

    // Model the effect of a complete word.
    task automatic model_word(input logic [11:0] w);
        if (w[9:8] == 2'b10) e_err++;
        else if (w[2:0] == 3'b101) begin m_cfg = 12'h000; m_tog = 1'b0; e_rst++; end
        else begin
            m_cfg = {w[11:3], 3'b000};
            if (w[2:0] == 3'b001) e_wr++;
            if (w[2:0] == 3'b011) e_rd++;
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R2/R8 chan"}, {10'd0, chan_code}, {10'd0, exp_chan()});
        chk({tag, " R8 pos/neg"}, {9'd0, pos_sel, neg_sel},
            {9'd0, exp_pos(exp_chan()), exp_chan() == 2'b11});
        chk({tag, " R7 power"}, {7'd0, pd_deep, pd_nap, pd_autonap, pd_ref, special_rd},
            {7'd0, m_cfg[7:3]});
        chk({tag, " R11 feat"}, {9'd0, feat_code, extra_en},
            {9'd0, m_cfg[9:8], m_cfg[9:8] == 2'b01});
        chk({tag, " R10 dual"}, {11'd0, dual_out}, {11'd0, ~mode_single});
        chk({tag, " R4 wr count"}, 12'(n_wr), 12'(e_wr));
        chk({tag, " R4 rd count"}, 12'(n_rd), 12'(e_rd));
        chk({tag, " R5 rst count"}, 12'(n_rst), 12'(e_rst));
        chk({tag, " R6 err count"}, 12'(n_err), 12'(e_err));
    endtask

    // Send nbits of a frame; bits past 12 come from extra.
    task automatic send(input logic [11:0] w, input int nbits, input logic [3:0] extra);
        @(negedge clk); ser_sel = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            ser_clk = 1'b0;
            ser_din = (i < 12) ? w[11-i] : extra[i % 4];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
        end
        ser_sel = 1'b0;
        repeat (4) @(negedge clk);
        if (nbits >= 12) model_word(w);
    endtask

    task automatic pulse_conv();
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        if (mode_auto) m_tog = ~m_tog;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        send(12'b00_00_1010_1_001, 12, 4'h0);  check_all("R2 R4 dac write");
        send(12'b01_00_0101_0_011, 12, 4'h0);  check_all("R4 dac read");
        send(12'b10_01_1111_1_110, 12, 4'h0);  check_all("R4 R11 no-op action");
        send(12'b11_11_0000_0_000, 12, 4'h0);  check_all("R8 code 11");
        send(12'b00_10_1111_1_001, 12, 4'h0);  check_all("R6 reserved");
        send(12'b01_00_1111_0_001, 7, 4'h0);   check_all("R3 partial");
        send(12'b01_01_0011_1_000, 15, 4'hF);  check_all("R3 extra clocks");

        mode_auto = 1'b1; @(negedge clk);
        check_all("R9 auto start");
        pulse_conv(); check_all("R9 auto toggle 1");
        send(12'b01_00_0000_0_000, 12, 4'h0);  check_all("R9 field ignored");
        pulse_conv(); check_all("R9 auto toggle 2");
        pulse_conv(); check_all("R9 auto toggle 3");
        send(12'b11_00_0000_0_101, 12, 4'h0);  check_all("R5 reset in auto");
        mode_auto = 1'b0; pulse_conv(); check_all("R9 conv ignored manual");
        mode_single = 1'b1; @(negedge clk); check_all("R10 single");

        for (int k = 0; k < 60; k++) begin
            int r, n;
            logic [11:0] w;
            mode_auto   = 1'($urandom);
            mode_single = 1'($urandom);
            w = 12'($urandom);
            r = int'($urandom % 8);
            n = (r == 0) ? int'(1 + $urandom % 11) : (r == 1) ? int'(13 + $urandom % 3) : 12;
            send(w, n, 4'($urandom));
            check_all("rand frame");
            if ($urandom % 2 == 1) begin
                pulse_conv();
                check_all("R9 rand conv");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule